// File: doc/BRIEF.md
# Trap Cause Prioritizer

This block sits beside the fetch, decode and memory stages of an in-order 32-bit core. Every cycle it looks at the detection flags of each synchronous exception source and picks the single one to report. It presents that choice as a valid flag, a 4-bit cause code and a trap value. Two of the fetch-side detectors live inside the block: the execute-address trigger comparison, and the PC alignment check, which depends on whether compressed instructions are enabled.

Each of the nine sources carries an elaboration-time level. Level 1 is examined first and level 7 last. Any value outside 1..7 (by convention 8) disables the source. When two enabled sources share a level, the one earlier in the default order wins. With the default levels the order, highest first, is:

1. fetch trigger
2. fetch misaligned
3. fetch access fault
4. illegal instruction
5. EBREAK
6. load/store trigger
7. load/store misaligned
8. load/store access fault
9. environment call

This order comes out of the levels 1..7 together with the tie rule. The selection is purely combinational.

Top module: `trap_prio`

## Requirements
- R1: The fetch trigger source is raised when fetch_valid and trig_exec_en are both high and pc equals trig_addr. It reports cause 3 with tval = pc.
- R2: The fetch misaligned source (cause 0, tval = pc) is raised when fetch_valid is high and the PC is misaligned. With rvc_en = 1 the PC is misaligned when pc[0] is set. With rvc_en = 0 it is misaligned when pc[1:0] is nonzero.
- R3: Among the raised and enabled sources, the one with the numerically lowest level is reported. With the default levels the default order holds.
- R4: When raised, enabled sources share the lowest level, the one earlier in the default order is reported.
- R5: A source whose level lies outside 1..7 is never reported, even when it is the only source raised.
- R6: The order of load/store misaligned and load/store access fault follows their level parameters alone. Swapping the two levels swaps which of them wins.
- R7: Cause codes are as follows:
  - fetch access fault: 1
  - illegal instruction: 2
  - EBREAK: 3
  - load/store trigger: 3
  - load/store misaligned: 4 when ls_is_store = 0, 6 when ls_is_store = 1
  - load/store access fault: 5 when ls_is_store = 0, 7 when ls_is_store = 1
- R8: An environment call reports cause 8 + priv, with priv encoded U = 00, S = 01, M = 11 (causes 8, 9, 11).
- R9: tval is:
  - pc for the fetch trigger, fetch misaligned, fetch fault, EBREAK and load/store trigger sources
  - instr_word for an illegal instruction
  - ls_addr for load/store misaligned and fault
  - zero for an environment call
- R10: When no enabled source is raised, exc_valid is 0 and exc_cause and exc_tval are 0.
- R11: The outputs follow the inputs combinationally, in the same cycle, with no register on the path.
- R12: fetch_fault, illegal, is_ebreak and is_ecall count only while fetch_valid is high. ls_trig, ls_misal and ls_fault do not depend on fetch_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_valid | input | 1 | A fetched instruction is present this cycle |
| pc | input | XLEN | PC of the fetched instruction |
| rvc_en | input | 1 | Compressed instructions enabled (16-bit alignment) |
| trig_exec_en | input | 1 | Execute-address trigger enable (bit 2 of the trigger control CSR) |
| trig_addr | input | XLEN | Trigger match address |
| fetch_fault | input | 1 | Fetch access fault detected |
| illegal | input | 1 | Decoder flags the instruction as illegal |
| instr_word | input | XLEN | Raw instruction word |
| is_ebreak | input | 1 | Instruction is EBREAK |
| is_ecall | input | 1 | Instruction is ECALL |
| priv | input | 2 | Current privilege mode (U = 00, S = 01, M = 11) |
| ls_trig | input | 1 | Load/store address trigger hit |
| ls_misal | input | 1 | Load/store address misaligned |
| ls_fault | input | 1 | Load/store access fault |
| ls_is_store | input | 1 | The memory access is a store or AMO |
| ls_addr | input | XLEN | Effective load/store address |
| exc_valid | output | 1 | An exception is reported |
| exc_cause | output | 4 | Cause code |
| exc_tval | output | XLEN | Trap value |

## Verification
Every result of this block is due in the same cycle as the flags that produce it, zero clock edges later. The bench therefore drives a new stimulus just after a rising clock edge and samples all outputs at the following falling edge, with no register to count in between. Two instances run side by side: one with the default levels, and one with a disabled trigger, a disabled environment call, illegal instruction promoted to level 1 and the load/store pair swapped. This shows the same stimulus resolving differently under each configuration in that same sample.

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int XLEN       = 32,
  parameter int LVL_ITRIG  = 1,
  parameter int LVL_IMIS   = 2,
  parameter int LVL_IFAULT = 3,
  parameter int LVL_ILL    = 4,
  parameter int LVL_EBRK   = 5,
  parameter int LVL_LSTRIG = 6,
  parameter int LVL_LSMIS  = 7,
  parameter int LVL_LSFLT  = 7,
  parameter int LVL_ECALL  = 7
) (
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] pc,
  input  logic            rvc_en,
  input  logic            trig_exec_en,
  input  logic [XLEN-1:0] trig_addr,
  input  logic            fetch_fault,
  input  logic            illegal,
  input  logic [XLEN-1:0] instr_word,
  input  logic            is_ebreak,
  input  logic            is_ecall,
  input  logic [1:0]      priv,
  input  logic            ls_trig,
  input  logic            ls_misal,
  input  logic            ls_fault,
  input  logic            ls_is_store,
  input  logic [XLEN-1:0] ls_addr,
  output logic            exc_valid,
  output logic [3:0]      exc_cause,
  output logic [XLEN-1:0] exc_tval
);
  localparam int NSRC = 9;
  localparam int LVL_MIN = 1;
  localparam int LVL_MAX = 7;
  localparam int LVL [NSRC] = '{LVL_ITRIG, LVL_IMIS, LVL_IFAULT, LVL_ILL, LVL_EBRK,
                                 LVL_LSTRIG, LVL_LSMIS, LVL_LSFLT, LVL_ECALL};

  logic [NSRC-1:0] hit, elig, win;

  assign hit[0] = fetch_valid && trig_exec_en && (pc == trig_addr);
  assign hit[1] = fetch_valid && (rvc_en ? pc[0] : |pc[1:0]);
  assign hit[2] = fetch_valid && fetch_fault;
  assign hit[3] = fetch_valid && illegal;
  assign hit[4] = fetch_valid && is_ebreak;
  assign hit[5] = ls_trig;
  assign hit[6] = ls_misal;
  assign hit[7] = ls_fault;
  assign hit[8] = fetch_valid && is_ecall;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic beaten;
    assign elig[i] = hit[i] && (LVL[i] >= LVL_MIN) && (LVL[i] <= LVL_MAX);
    always_comb begin
      beaten = 1'b0;
      for (int j = 0; j < NSRC; j++)
        if (j != i && elig[j] && (LVL[j] < LVL[i] || (LVL[j] == LVL[i] && j < i)))
          beaten = 1'b1;
    end
    assign win[i] = elig[i] && !beaten;
  end

  assign exc_valid = |win;

  always_comb begin
    exc_cause = '0;
    exc_tval  = '0;
    if (win[0] || win[4] || win[5]) begin
      exc_cause = 4'd3;
      exc_tval  = pc;
    end
    if (win[1]) exc_tval = pc;
    if (win[2]) begin
      exc_cause = 4'd1;
      exc_tval  = pc;
    end
    if (win[3]) begin
      exc_cause = 4'd2;
      exc_tval  = instr_word;
    end
    if (win[6]) begin
      exc_cause = ls_is_store ? 4'd6 : 4'd4;
      exc_tval  = ls_addr;
    end
    if (win[7]) begin
      exc_cause = ls_is_store ? 4'd7 : 4'd5;
      exc_tval  = ls_addr;
    end
    if (win[8]) exc_cause = {2'b10, priv};
  end
endmodule

// File: rtl/trap_prio_chk.sv
module trap_prio_chk #(
  parameter int XLEN      = 32,
  parameter int LVL_ILL   = 4,
  parameter int LVL_ECALL = 7
) (
  input logic            fetch_valid,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr_word,
  input logic            ls_trig,
  input logic            ls_misal,
  input logic            ls_fault,
  input logic [XLEN-1:0] ls_addr,
  input logic            exc_valid,
  input logic [3:0]      exc_cause,
  input logic [XLEN-1:0] exc_tval
);
  localparam bit ILL_OFF   = (LVL_ILL < 1) || (LVL_ILL > 7);
  localparam bit ECALL_OFF = (LVL_ECALL < 1) || (LVL_ECALL > 7);

  always_comb begin
    // R10
    if (!exc_valid) idle_zero_chk: assert (exc_cause == 4'd0 && exc_tval == '0);
    // R12
    if (!fetch_valid && !ls_trig && !ls_misal && !ls_fault)
      no_source_chk: assert (!exc_valid);
    // R9
    if (exc_valid && exc_cause == 4'd2) tval_ill_chk: assert (exc_tval == instr_word);
    // R9
    if (exc_valid && exc_cause >= 4'd4 && exc_cause <= 4'd7)
      tval_mem_chk: assert (exc_tval == ls_addr);
    // R9
    if (exc_valid && exc_cause <= 4'd1) tval_fetch_chk: assert (exc_tval == pc);
    // R8
    if (exc_valid && exc_cause >= 4'd8)
      ecall_chk: assert (exc_tval == '0 && exc_cause != 4'd10 && fetch_valid);
    // R5
    if (ECALL_OFF) ecall_off_chk: assert (!(exc_valid && exc_cause >= 4'd8));
    // R5
    if (ILL_OFF) ill_off_chk: assert (!(exc_valid && exc_cause == 4'd2));
  end
endmodule

bind trap_prio trap_prio_chk #(.XLEN(XLEN), .LVL_ILL(LVL_ILL), .LVL_ECALL(LVL_ECALL)) chk (
  .fetch_valid(fetch_valid), .pc(pc), .instr_word(instr_word), .ls_trig(ls_trig),
  .ls_misal(ls_misal), .ls_fault(ls_fault), .ls_addr(ls_addr), .exc_valid(exc_valid),
  .exc_cause(exc_cause), .exc_tval(exc_tval)
);

// File: tb/trap_prio_test.sv
`timescale 1ns/1ps
module trap_prio_test;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic fetch_valid, rvc_en, trig_exec_en, fetch_fault, illegal, is_ebreak, is_ecall;
  logic ls_trig, ls_misal, ls_fault, ls_is_store;
  logic [31:0] pc, trig_addr, instr_word, ls_addr;
  logic [1:0] priv;
  logic v0, v1;
  logic [3:0] c0, c1;
  logic [31:0] t0, t1;
  int checks = 0, errors = 0;
  bit done = 0;

  int lv_def [9] = '{1, 2, 3, 4, 5, 6, 7, 7, 7};
  int lv_alt [9] = '{8, 2, 3, 1, 5, 6, 7, 6, 8};

  trap_prio uut (.fetch_valid, .pc, .rvc_en, .trig_exec_en, .trig_addr, .fetch_fault,
    .illegal, .instr_word, .is_ebreak, .is_ecall, .priv, .ls_trig, .ls_misal, .ls_fault,
    .ls_is_store, .ls_addr, .exc_valid(v0), .exc_cause(c0), .exc_tval(t0));

  trap_prio #(.LVL_ITRIG(8), .LVL_ILL(1), .LVL_LSMIS(7), .LVL_LSFLT(6), .LVL_ECALL(8)) uut_alt (
    .fetch_valid, .pc, .rvc_en, .trig_exec_en, .trig_addr, .fetch_fault,
    .illegal, .instr_word, .is_ebreak, .is_ecall, .priv, .ls_trig, .ls_misal, .ls_fault,
    .ls_is_store, .ls_addr, .exc_valid(v1), .exc_cause(c1), .exc_tval(t1));

  function automatic void model(input int lv [9], output logic ev, output logic [3:0] ec,
                                output logic [31:0] et);
    logic h [9];
    int best;
    h[0] = fetch_valid && trig_exec_en && pc == trig_addr;
    h[1] = fetch_valid && (rvc_en ? pc[0] : pc[1:0] != 2'b00);
    h[2] = fetch_valid && fetch_fault;
    h[3] = fetch_valid && illegal;
    h[4] = fetch_valid && is_ebreak;
    h[5] = ls_trig;
    h[6] = ls_misal;
    h[7] = ls_fault;
    h[8] = fetch_valid && is_ecall;
    best = -1;
    for (int i = 0; i < 9; i++)
      if (h[i] && lv[i] >= 1 && lv[i] <= 7 && (best < 0 || lv[i] < lv[best])) best = i;
    ev = best >= 0;
    ec = 0;
    et = 0;
    case (best)
      0, 4, 5: begin ec = 3; et = pc; end
      1: begin ec = 0; et = pc; end
      2: begin ec = 1; et = pc; end
      3: begin ec = 2; et = instr_word; end
      6: begin ec = ls_is_store ? 4'd6 : 4'd4; et = ls_addr; end
      7: begin ec = ls_is_store ? 4'd7 : 4'd5; et = ls_addr; end
      8: ec = 4'd8 + {2'b00, priv};
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic gv, input logic [3:0] gc,
                       input logic [31:0] gt, input logic ev, input logic [3:0] ec,
                       input logic [31:0] et);
    checks++;
    if (gv !== ev || gc !== ec || gt !== et) begin
      errors++;
      $display("FAIL %s: got valid=%0b cause=%0d tval=%h, expected valid=%0b cause=%0d tval=%h",
               req, gv, gc, gt, ev, ec, et);
    end
  endtask

  task automatic clear();
    fetch_valid = 0; rvc_en = 1; trig_exec_en = 0; fetch_fault = 0; illegal = 0;
    is_ebreak = 0; is_ecall = 0; ls_trig = 0; ls_misal = 0; ls_fault = 0; ls_is_store = 0;
    pc = 32'h100; trig_addr = 32'h0; instr_word = 32'hdead_beef; ls_addr = 32'h2003; priv = 2'b11;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    rst = 0;
    settle();
    // R10 idle outputs
    check("R10 default", v0, c0, t0, 0, 0, 0);
    check("R10 alt", v1, c1, t1, 0, 0, 0);

    // R1, R11: driven after a rising edge, sampled at the next falling edge
    @(posedge clk); clear(); fetch_valid = 1; trig_exec_en = 1; trig_addr = 32'h100; settle();
    check("R1 R11 trigger match", v0, c0, t0, 1, 3, 32'h100);
    check("R5 trigger disabled", v1, c1, t1, 0, 0, 0);
    @(posedge clk); trig_addr = 32'h104; settle();
    check("R1 address mismatch", v0, c0, t0, 0, 0, 0);

    // R2 alignment
    @(posedge clk); clear(); fetch_valid = 1; pc = 32'h102; settle();
    check("R2 rvc half aligned", v0, c0, t0, 0, 0, 0);
    @(posedge clk); rvc_en = 0; settle();
    check("R2 no rvc misaligned", v0, c0, t0, 1, 0, 32'h102);
    @(posedge clk); rvc_en = 1; pc = 32'h101; settle();
    check("R2 rvc odd", v0, c0, t0, 1, 0, 32'h101);

    // R3 all sources: trigger wins by default, illegal wins in alt
    @(posedge clk); clear(); fetch_valid = 1; trig_exec_en = 1; trig_addr = 32'h100;
    fetch_fault = 1; illegal = 1; is_ebreak = 1; is_ecall = 1;
    ls_trig = 1; ls_misal = 1; ls_fault = 1; settle();
    check("R3 default order", v0, c0, t0, 1, 3, 32'h100);
    check("R3 R5 R9 alt illegal", v1, c1, t1, 1, 2, 32'hdead_beef);
    @(posedge clk); trig_exec_en = 0; settle();
    check("R3 R7 fetch fault", v0, c0, t0, 1, 1, 32'h100);

    // R6 swap, R7 store codes
    @(posedge clk); clear(); ls_misal = 1; ls_fault = 1; ls_is_store = 1; settle();
    check("R6 R7 default store misal", v0, c0, t0, 1, 6, 32'h2003);
    check("R6 R7 alt store fault", v1, c1, t1, 1, 7, 32'h2003);
    // R4 tie at level 7 among misal, fault, ecall
    @(posedge clk); ls_is_store = 0; fetch_valid = 1; is_ecall = 1; settle();
    check("R4 tie load misal", v0, c0, t0, 1, 4, 32'h2003);
    check("R6 R7 alt load fault", v1, c1, t1, 1, 5, 32'h2003);

    // R8 ecall per privilege, R5 disabled in alt
    @(posedge clk); clear(); fetch_valid = 1; is_ecall = 1; priv = 2'b11; settle();
    check("R8 M ecall", v0, c0, t0, 1, 11, 0);
    check("R5 ecall disabled", v1, c1, t1, 0, 0, 0);
    @(posedge clk); priv = 2'b01; settle();
    check("R8 S ecall", v0, c0, t0, 1, 9, 0);
    @(posedge clk); priv = 2'b00; settle();
    check("R8 U ecall", v0, c0, t0, 1, 8, 0);
    @(posedge clk); is_ecall = 0; is_ebreak = 1; settle();
    check("R7 R9 ebreak", v0, c0, t0, 1, 3, 32'h100);

    // R12 fetch-side flags gated, memory flags not
    @(posedge clk); clear(); fetch_fault = 1; illegal = 1; is_ebreak = 1; is_ecall = 1;
    pc = 32'h103; settle();
    check("R12 gated by fetch_valid", v0, c0, t0, 0, 0, 0);
    check("R12 gated by fetch_valid alt", v1, c1, t1, 0, 0, 0);
    @(posedge clk); ls_fault = 1; settle();
    check("R12 R7 load fault ungated", v0, c0, t0, 1, 5, 32'h2003);
    @(posedge clk); ls_fault = 0; ls_trig = 1; settle();
    check("R7 R9 ls trigger", v0, c0, t0, 1, 3, 32'h103);

    // R3 random mix against the model, both configurations
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic ev; logic [3:0] ec; logic [31:0] et;
      @(posedge clk);
      fetch_valid = ($urandom % 4) != 0;
      pc = $urandom & 32'h0000_0fff;
      rvc_en = $urandom % 2;
      trig_exec_en = $urandom % 2;
      trig_addr = ($urandom % 2) ? pc : ($urandom & 32'h0000_0fff);
      fetch_fault = ($urandom % 5) == 0;
      illegal = ($urandom % 5) == 0;
      is_ebreak = ($urandom % 6) == 0;
      is_ecall = ($urandom % 4) == 0;
      instr_word = $urandom;
      priv = ($urandom % 2) ? 2'b11 : 2'($urandom % 2);
      ls_trig = ($urandom % 6) == 0;
      ls_misal = ($urandom % 4) == 0;
      ls_fault = ($urandom % 4) == 0;
      ls_is_store = $urandom % 2;
      ls_addr = $urandom;
      settle();
      model(lv_def, ev, ec, et);
      check("R3 random default", v0, c0, t0, ev, ec, et);
      model(lv_alt, ev, ec, et);
      check("R3 random alt", v1, c1, t1, ev, ec, et);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule